// File: doc/BRIEF.md
# PCI Power State Controller

This block owns the two-bit device power-state field of a PCI power-management capability. It watches configuration writes on a simple dword-addressed bus. When a write hits the low byte of the power-management control/status register, the block checks the requested D-state against the D1/D2 support bits and the allowed direction of travel. A legal request is committed. An illegal one is reverted: the field keeps its old value, and a one-cycle reject report gives the old and the requested state.

Memory and I/O BAR decoding is allowed only while the device sits in D0. In every other state the BARs count as unmapped, so the surrounding logic answers their accesses with an Unsupported Request completion. When an accepted write carries the device into D0 or out of it, the block pulses a remap request so that address decoding is rebuilt. A per-device write mask input can make the field read-only.

The core is a four-state machine: `PS_D0`, `PS_D1`, `PS_D2` and `PS_D3HOT`, encoded 0 to 3. Its transitions are:
- Wake: any state goes to `PS_D0`.
- Enter: `PS_D0` goes to any supported deeper state.
- Deepen: a non-D0 state goes to a numerically higher one, provided that state is supported.

Every other request is refused with a **reject**. A request for the current state is a **hold**.

Top module: `pci_pm_state_ctrl`

## Requirements
- R1: A request for D1 (value 1) while `cap_d1_ok` is low is rejected; with `cap_d1_ok` high, D0 to D1 is accepted.
- R2: A request for D2 (value 2) while `cap_d2_ok` is low is rejected; with `cap_d2_ok` high, D0 to D2 and D1 to D2 are accepted.
- R3: When both the current and the requested state are non-D0, the request is accepted only if it is numerically higher (D1 to D3hot accepted; D3hot to D2 and D2 to D1 rejected).
- R4: A request for D0 (value 0) is accepted from every state.
- R5: On a rejected request the state is unchanged, and one cycle after the write `rej_valid` is high for exactly one cycle with `rej_from` equal to the old state and `rej_to` equal to the requested state.
- R6: Reset forces the state to D0: `pwr_state` reads 0, `bar_decode_en` is high, and `remap_req` and `rej_valid` are low.
- R7: `bar_decode_en` is high exactly when `pwr_state` is D0.
- R8: A write takes part in transition checking only if `cfg_addr` equals the dword of the control/status register and the byte enable of its low byte is set. The requested state is bits [1:0] of that byte. Any other write leaves the state and both pulse outputs untouched.
- R9: A write requesting the current state is a hold: no state change, no remap pulse, no reject report.
- R10: `remap_req` is high for exactly one cycle, the cycle after an accepted write that moves into or out of D0. A move between two non-D0 states does not raise it.
- R11: While `pm_wr_mask` is low, the state field is read-only: writes change nothing and raise neither pulse.
- R12: An accepted write updates `pwr_state` on the first clock edge after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | ADDR_W | Configuration dword address |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cap_d1_ok | input | 1 | D1 supported bit from the capabilities register |
| cap_d2_ok | input | 1 | D2 supported bit from the capabilities register |
| pm_wr_mask | input | 1 | Write mask for the state field; low makes it read-only |
| pwr_state | output | 2 | Current D-state (0=D0, 1=D1, 2=D2, 3=D3hot) |
| bar_decode_en | output | 1 | BAR decoding allowed (D0 only) |
| remap_req | output | 1 | One-cycle pulse on crossing the D0 boundary |
| rej_valid | output | 1 | One-cycle pulse on a rejected transition |
| rej_from | output | 2 | State held when the rejected request arrived |
| rej_to | output | 2 | State that was requested and refused |

## Verification
The state machine is driven along legal paths: enter D1, deepen to D3hot, wake to D0, enter D2. Each step shows whether accepted moves commit and whether the remap pulse separates D0 crossings from moves between non-D0 states. Downward moves between non-D0 states, and D1/D2 requests with the support bits cleared, tell the direction rule apart from the support rule, and each must raise a reject report that names the right old and requested states. Holds and writes that miss the address or the low byte lane check that the decode qualifies a write, and that a no-change write raises no pulse. Writes with the mask cleared, and a reset taken from D3hot, check that the field can be locked and that reset returns it to D0.

// File: rtl/pci_pm_pkg.sv
package pci_pm_pkg;

    typedef enum logic [1:0] {
        PS_D0    = 2'd0,
        PS_D1    = 2'd1,
        PS_D2    = 2'd2,
        PS_D3HOT = 2'd3
    } pstate_e;

    localparam int unsigned STATE_W = 2;
    localparam int unsigned BE_W    = 4;
    localparam int unsigned DATA_W  = 32;

endpackage

// File: rtl/pci_pm_wr_decode.sv
module pci_pm_wr_decode
    import pci_pm_pkg::*;
#(
    parameter int unsigned ADDR_W         = 10,
    parameter int unsigned CTRL_BYTE_ADDR = 12'h044
) (
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              ctrl_hit,
    output pstate_e           req_state
);

    localparam int unsigned       LANE    = CTRL_BYTE_ADDR % BE_W;
    localparam logic [ADDR_W-1:0] CTRL_DW = ADDR_W'(CTRL_BYTE_ADDR / BE_W);

    logic unused_bits;

    // A write is relevant only when it lands on the control dword and
    // its enable covers the byte that holds the state field.
    assign ctrl_hit    = cfg_wr && (cfg_addr == CTRL_DW) && cfg_be[LANE];
    assign req_state   = pstate_e'(cfg_wdata[LANE*8 +: STATE_W]);
    assign unused_bits = ^{cfg_wdata, cfg_be};

endmodule

// File: rtl/pci_pm_fsm.sv
module pci_pm_fsm
    import pci_pm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ctrl_hit,
    input  pstate_e req_state,
    input  logic    cap_d1_ok,
    input  logic    cap_d2_ok,
    input  logic    pm_wr_mask,
    output pstate_e cur_state,
    output logic    remap_req,
    output logic    rej_valid,
    output pstate_e rej_from,
    output pstate_e rej_to
);

    pstate_e state_q, state_d;
    logic    attempt;
    logic    legal;
    logic    target_ok;

    // Support check for the requested state alone.
    always_comb begin
        unique case (req_state)
            PS_D1:   target_ok = cap_d1_ok;
            PS_D2:   target_ok = cap_d2_ok;
            default: target_ok = 1'b1;
        endcase
    end

    // A change attempt is a qualified write asking for another state.
    assign attempt = ctrl_hit && pm_wr_mask && (req_state != state_q);

    // Legality of each transition out of the current state.
    always_comb begin
        unique case (state_q)
            PS_D0:    legal = target_ok;
            PS_D1:    legal = (req_state == PS_D0) ||
                              ((req_state > PS_D1) && target_ok);
            PS_D2:    legal = (req_state == PS_D0) || (req_state == PS_D3HOT);
            PS_D3HOT: legal = (req_state == PS_D0);
            default:  legal = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (attempt && legal) begin
            state_d = req_state;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_D0;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: remap and reject pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap_req <= 1'b0;
            rej_valid <= 1'b0;
            rej_from  <= PS_D0;
            rej_to    <= PS_D0;
        end else begin
            remap_req <= attempt && legal &&
                         ((state_q == PS_D0) != (req_state == PS_D0));
            rej_valid <= attempt && !legal;
            if (attempt && !legal) begin
                rej_from <= state_q;
                rej_to   <= req_state;
            end
        end
    end

    assign cur_state = state_q;

    AST_D1_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_D1) && ($past(state_q) != PS_D1) |-> $past(cap_d1_ok)); // R1

    AST_D2_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_D2) && ($past(state_q) != PS_D2) |-> $past(cap_d2_ok)); // R2

    AST_ONLY_DEEPER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_D0) && ($past(state_q) != PS_D0) && (state_q != $past(state_q))
        |-> (state_q > $past(state_q))); // R3

    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> (state_q == $past(state_q)) && (rej_from == state_q)); // R5

    AST_REMAP_CROSSES: assert property (@(posedge clk) disable iff (!rst_n)
        remap_req |-> ((state_q == PS_D0) != ($past(state_q) == PS_D0))); // R10

    AST_MASK_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pm_wr_mask) |-> $stable(state_q) && !remap_req && !rej_valid); // R11

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(remap_req && rej_valid)); // R5

endmodule

// File: rtl/pci_pm_state_ctrl.sv
module pci_pm_state_ctrl
    import pci_pm_pkg::*;
#(
    parameter int unsigned ADDR_W         = 10,
    parameter int unsigned CTRL_BYTE_ADDR = 12'h044
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic              cap_d1_ok,
    input  logic              cap_d2_ok,
    input  logic              pm_wr_mask,
    output logic [1:0]        pwr_state,
    output logic              bar_decode_en,
    output logic              remap_req,
    output logic              rej_valid,
    output logic [1:0]        rej_from,
    output logic [1:0]        rej_to
);

    logic    ctrl_hit;
    pstate_e req_state;
    pstate_e cur_state;
    pstate_e rej_from_s;
    pstate_e rej_to_s;

    pci_pm_wr_decode #(
        .ADDR_W         (ADDR_W),
        .CTRL_BYTE_ADDR (CTRL_BYTE_ADDR)
    ) u_decode (
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .ctrl_hit  (ctrl_hit),
        .req_state (req_state)
    );

    pci_pm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_hit   (ctrl_hit),
        .req_state  (req_state),
        .cap_d1_ok  (cap_d1_ok),
        .cap_d2_ok  (cap_d2_ok),
        .pm_wr_mask (pm_wr_mask),
        .cur_state  (cur_state),
        .remap_req  (remap_req),
        .rej_valid  (rej_valid),
        .rej_from   (rej_from_s),
        .rej_to     (rej_to_s)
    );

    assign pwr_state     = cur_state;
    assign rej_from      = rej_from_s;
    assign rej_to        = rej_to_s;
    assign bar_decode_en = (cur_state == PS_D0);

    AST_BAR_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        remap_req && bar_decode_en |-> $past(pwr_state) != 2'd0); // R7

endmodule

// File: tb/pci_pm_state_ctrl_tb.sv
module pci_pm_state_ctrl_tb;

    localparam int unsigned ADDR_W = 10;
    localparam logic [ADDR_W-1:0] CTRL_DW = 10'h011;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_wr;
    logic [ADDR_W-1:0] cfg_addr;
    logic [3:0]        cfg_be;
    logic [31:0]       cfg_wdata;
    logic              cap_d1_ok, cap_d2_ok, pm_wr_mask;
    logic [1:0]        pwr_state, rej_from, rej_to;
    logic              bar_decode_en, remap_req, rej_valid;

    int checks = 0;
    int fails  = 0;
    logic s_remap, s_rej;
    logic [1:0] s_from, s_to;

    always #2.5 clk = ~clk;

    pci_pm_state_ctrl #(.ADDR_W(ADDR_W), .CTRL_BYTE_ADDR(12'h044)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cap_d1_ok(cap_d1_ok),
        .cap_d2_ok(cap_d2_ok), .pm_wr_mask(pm_wr_mask), .pwr_state(pwr_state),
        .bar_decode_en(bar_decode_en), .remap_req(remap_req),
        .rej_valid(rej_valid), .rej_from(rej_from), .rej_to(rej_to)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One write cycle; pulses are sampled in the cycle after the edge.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        s_remap = remap_req; s_rej = rej_valid; s_from = rej_from; s_to = rej_to;
    endtask

    task automatic req(input logic [1:0] st);
        wr(CTRL_DW, 4'b0001, {30'h3ABCDE0, st});
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R6 state", pwr_state, 0);
        chk("R6 bar", bar_decode_en, 1);
        chk("R6 remap", remap_req, 0);
        chk("R6 rej", rej_valid, 0);
    endtask

    task automatic t_legal_path;
        cap_d1_ok = 1; cap_d2_ok = 1;
        req(2'd1);
        chk("R1 R12 D0->D1 state", pwr_state, 1);
        chk("R10 enter remap", s_remap, 1);
        chk("R7 bar off", bar_decode_en, 0);
        @(negedge clk);
        chk("R10 single pulse", remap_req, 0);
        req(2'd3);
        chk("R3 D1->D3 state", pwr_state, 3);
        chk("R10 no remap nonD0", s_remap, 0);
        chk("R3 no reject", s_rej, 0);
        req(2'd0);
        chk("R4 D3->D0 state", pwr_state, 0);
        chk("R10 wake remap", s_remap, 1);
        chk("R7 bar on", bar_decode_en, 1);
        req(2'd2);
        chk("R2 D0->D2 state", pwr_state, 2);
        req(2'd0);
        req(2'd1);
        req(2'd2);
        chk("R2 D1->D2 state", pwr_state, 2);
    endtask

    task automatic t_reject_direction;
        req(2'd1);
        chk("R3 D2->D1 state", pwr_state, 2);
        chk("R5 rej pulse", s_rej, 1);
        chk("R5 rej from", s_from, 2);
        chk("R5 rej to", s_to, 1);
        chk("R5 no remap", s_remap, 0);
        @(negedge clk);
        chk("R5 rej one cycle", rej_valid, 0);
        req(2'd3);
        req(2'd2);
        chk("R3 D3->D2 state", pwr_state, 3);
        chk("R5 rej from D3", s_from, 3);
        chk("R5 rej to D2", s_to, 2);
        req(2'd0);
        chk("R4 back D0", pwr_state, 0);
    endtask

    task automatic t_caps;
        cap_d1_ok = 0; cap_d2_ok = 0;
        req(2'd1);
        chk("R1 unsupported D1 state", pwr_state, 0);
        chk("R1 rej", s_rej, 1);
        req(2'd2);
        chk("R2 unsupported D2 state", pwr_state, 0);
        chk("R2 rej to", s_to, 2);
        req(2'd3);
        chk("R4 D3 still ok", pwr_state, 3);
        req(2'd0);
        cap_d1_ok = 1; cap_d2_ok = 1;
    endtask

    task automatic t_hold_and_miss;
        req(2'd0);
        chk("R9 hold state", pwr_state, 0);
        chk("R9 hold no remap", s_remap, 0);
        chk("R9 hold no rej", s_rej, 0);
        wr(CTRL_DW, 4'b1110, 32'hFFFF_FF03);
        chk("R8 lane miss state", pwr_state, 0);
        chk("R8 lane miss remap", s_remap, 0);
        wr(CTRL_DW + 10'd1, 4'b1111, 32'h0000_0003);
        chk("R8 addr miss state", pwr_state, 0);
        wr(CTRL_DW, 4'b0001, 32'hFFFF_FF03);
        chk("R8 upper bits ignored", pwr_state, 3);
    endtask

    task automatic t_mask;
        pm_wr_mask = 0;
        req(2'd0);
        chk("R11 locked state", pwr_state, 3);
        chk("R11 locked no remap", s_remap, 0);
        chk("R11 locked no rej", s_rej, 0);
        req(2'd1);
        chk("R11 locked illegal no rej", s_rej, 0);
        pm_wr_mask = 1;
    endtask

    task automatic t_reset_from_d3;
        chk("R6 pre-reset D3", pwr_state, 3);
        do_reset();
        chk("R6 reset state", pwr_state, 0);
        chk("R6 reset bar", bar_decode_en, 1);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        cfg_wr = 0; cfg_addr = '0; cfg_be = '0; cfg_wdata = '0;
        cap_d1_ok = 1; cap_d2_ok = 1; pm_wr_mask = 1;
        s_remap = 0; s_rej = 0; s_from = '0; s_to = '0;
        do_reset();
        t_reset();
        t_legal_path();
        t_reject_direction();
        t_caps();
        t_hold_and_miss();
        t_mask();
        t_reset_from_d3();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule